// File: doc/BRIEF.md
# Dual-Counter PWM Gray-Shade Comparator Bank

This block turns a bank of 2-bit column intensity codes into pulse-width-modulated column enables for a gray-shade flat-panel driver. Two small master counters, one for red columns and one for green columns, are forced to zero while a load strobe is high. Once the strobe drops, each counter climbs by one on every rising edge of its own count clock. Every column compares its code against the counter of its colour and is driven high while its code is strictly greater than that count. A larger code therefore stays on for more count steps, which gives four distinct pulse widths.

The strobe and both count clocks are asynchronous to the system clock. Each one passes through a synchronizer and an edge detector before it reaches a counter. All column enables come from one register bank, so every column updates on the same system clock edge. Counters stop at the top code value instead of wrapping, so no column turns on a second time within one conversion cycle. A parameter sets whether the odd-numbered columns follow the red or the green counter.

Top module: `pwm_gray_bank`

## Requirements
- R1: While rst_n is low, every bit of col_out is 0 and both counters are 0. After reset is released with load_strobe low and no count edges, col_out[i] equals (code of column i > 0).
- R2: While the synchronized load_strobe is high, both counters are held at 0. Count clock edges that arrive during that time have no effect on col_out.
- R3: With the strobe low, each rising edge of red_cclk advances the red counter by exactly one. Levels and falling edges of red_cclk do not change it.
- R4: The green counter advances only on rising edges of green_cclk, independently of the red counter.
- R5: col_out[i] is 1 exactly when the code of column i is greater than the counter assigned to that column. A code of k stays high for k count steps after the strobe falls.
- R6: A counter that has reached 3 stays at 3 on further count edges, so every column of that colour stays low until the next strobe.
- R7: With RED_ON_EVEN=1, columns with an even index i (column number i+1 is odd) use the red counter and odd indices use green. With RED_ON_EVEN=0 the assignment is swapped.
- R8: Column i takes its code from code_bus[2i+1:2i], and bit 2i+1 is the most significant bit.
- R9: An input edge applied between system clock edges leaves col_out unchanged after three rising clk edges and shows on col_out after the fourth. All columns change on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| load_strobe | input | 1 | Asynchronous strobe; while high it clears both counters |
| red_cclk | input | 1 | Asynchronous count clock for the red counter |
| green_cclk | input | 1 | Asynchronous count clock for the green counter |
| code_bus | input | NUM_COL*CODE_W (128) | Latched column codes, CODE_W bits per column |
| col_out | output | NUM_COL (64) | Registered PWM column enables |

## Verification
The bench drives count edges while the strobe is high. A design that lets the counters run during load would cut pulses short. It drives red and green edges in separate bursts, which exposes any shared counter or swapped column assignment, and it compares a second instance built with the other colour assignment. It keeps pulsing past the top count to catch a counter that wraps and turns columns back on. It also uses single-column codes with only the MSB or only the LSB set, which shows a misplaced code field or reversed bit order. Finally it checks the exact edge on which an output changes, which catches a synchronizer stage missing or added.

// File: rtl/pwm_gray_pkg.sv
package pwm_gray_pkg;
  localparam int unsigned DEF_COLS   = 64;
  localparam int unsigned DEF_CODE_W = 2;
  localparam int unsigned DEF_SYNC   = 2;

  typedef enum logic {CH_RED = 1'b0, CH_GREEN = 1'b1} chan_e;

  // Colour channel that drives column index idx
  function automatic chan_e col_channel(input int unsigned idx, input bit red_on_even);
    return (((idx % 2) == 0) == red_on_even) ? CH_RED : CH_GREEN;
  endfunction
endpackage

// File: rtl/pwm_edge_sync.sv
module pwm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level = sync_q[STAGES-1];
  assign rise  = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pwm_sat_counter.sv
module pwm_sat_counter #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clear | (step & (cnt_q != TOP));
    cnt_d  = clear ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/pwm_cmp_bank.sv
module pwm_cmp_bank #(
  parameter int unsigned NUM_COL     = 64,
  parameter int unsigned CODE_W      = 2,
  parameter bit          RED_ON_EVEN = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_COL*CODE_W-1:0]  codes,
  input  logic [CODE_W-1:0]          red_cnt,
  input  logic [CODE_W-1:0]          green_cnt,
  output logic [NUM_COL-1:0]         cols
);
  logic [NUM_COL-1:0] cols_d;
  logic [NUM_COL-1:0] cols_q;

  for (genvar i = 0; i < NUM_COL; i++) begin : g_col
    localparam pwm_gray_pkg::chan_e CH = pwm_gray_pkg::col_channel(i, RED_ON_EVEN);
    logic [CODE_W-1:0] ref_cnt;
    if (CH == pwm_gray_pkg::CH_RED) begin : g_red
      assign ref_cnt = red_cnt;
    end else begin : g_grn
      assign ref_cnt = green_cnt;
    end
    assign cols_d[i] = codes[i*CODE_W +: CODE_W] > ref_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cols_q <= '0;
    end else begin
      cols_q <= cols_d;
    end
  end

  assign cols = cols_q;
endmodule

// File: rtl/pwm_gray_bank.sv
module pwm_gray_bank #(
  parameter int unsigned NUM_COL     = pwm_gray_pkg::DEF_COLS,
  parameter int unsigned CODE_W      = pwm_gray_pkg::DEF_CODE_W,
  parameter int unsigned SYNC_STAGES = pwm_gray_pkg::DEF_SYNC,
  parameter bit          RED_ON_EVEN = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_strobe,
  input  logic                      red_cclk,
  input  logic                      green_cclk,
  input  logic [NUM_COL*CODE_W-1:0] code_bus,
  output logic [NUM_COL-1:0]        col_out
);
  logic              load_lvl;
  logic              load_rise;
  logic              red_lvl;
  logic              red_rise;
  logic              green_lvl;
  logic              green_rise;
  logic [CODE_W-1:0] red_cnt;
  logic [CODE_W-1:0] green_cnt;

  pwm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_load (
    .clk(clk), .rst_n(rst_n), .async_in(load_strobe), .level(load_lvl), .rise(load_rise)
  );
  pwm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_red (
    .clk(clk), .rst_n(rst_n), .async_in(red_cclk), .level(red_lvl), .rise(red_rise)
  );
  pwm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_green (
    .clk(clk), .rst_n(rst_n), .async_in(green_cclk), .level(green_lvl), .rise(green_rise)
  );

  pwm_sat_counter #(.W(CODE_W)) u_cnt_red (
    .clk(clk), .rst_n(rst_n), .clear(load_lvl), .step(red_rise), .count(red_cnt)
  );
  pwm_sat_counter #(.W(CODE_W)) u_cnt_green (
    .clk(clk), .rst_n(rst_n), .clear(load_lvl), .step(green_rise), .count(green_cnt)
  );

  pwm_cmp_bank #(.NUM_COL(NUM_COL), .CODE_W(CODE_W), .RED_ON_EVEN(RED_ON_EVEN)) u_cmp (
    .clk(clk), .rst_n(rst_n), .codes(code_bus),
    .red_cnt(red_cnt), .green_cnt(green_cnt), .cols(col_out)
  );
endmodule

// File: rtl/pwm_gray_bank_chk.sv
module pwm_gray_bank_chk #(
  parameter int unsigned CODE_W      = 2,
  parameter bit          RED_ON_EVEN = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_lvl,
  input logic              red_rise,
  input logic              green_rise,
  input logic [CODE_W-1:0] red_cnt,
  input logic [CODE_W-1:0] green_cnt,
  input logic [CODE_W-1:0] code0,
  input logic              col0
);
  localparam logic [CODE_W-1:0] TOP = '1;
  logic [CODE_W-1:0] col0_cnt;
  assign col0_cnt = RED_ON_EVEN ? red_cnt : green_cnt;

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load_lvl |=> (red_cnt == '0 && green_cnt == '0)); // R2
  AST_RED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_lvl && red_rise && red_cnt != TOP) |=> red_cnt == $past(red_cnt) + 1'b1); // R3
  AST_RED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_lvl && !red_rise) |=> $stable(red_cnt)); // R3
  AST_GREEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_lvl && green_rise && green_cnt != TOP) |=> green_cnt == $past(green_cnt) + 1'b1); // R4
  AST_GREEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_lvl && !green_rise) |=> $stable(green_cnt)); // R4
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_lvl && red_cnt == TOP) |=> red_cnt == TOP); // R6
  AST_COL0_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> col0 == ($past(code0) > $past(col0_cnt))); // R5
endmodule

bind pwm_gray_bank pwm_gray_bank_chk #(.CODE_W(CODE_W), .RED_ON_EVEN(RED_ON_EVEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_lvl(load_lvl), .red_rise(red_rise),
  .green_rise(green_rise), .red_cnt(red_cnt), .green_cnt(green_cnt),
  .code0(code_bus[CODE_W-1:0]), .col0(col_out[0])
);

// File: tb/pwm_gray_bank_tb.sv
module pwm_gray_bank_tb;
  localparam int NC = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic          rclk = 1'b0;
  logic          gclk = 1'b0;
  logic [2*NC-1:0] codes = '0;
  logic [NC-1:0] out_a;
  logic [NC-1:0] out_b;

  int rc = 0;
  int gc = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [NC-1:0] exp_a;
    logic [NC-1:0] exp_b;
    string         tag;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  pwm_gray_bank u_dut (
    .clk(clk), .rst_n(rst_n), .load_strobe(load), .red_cclk(rclk),
    .green_cclk(gclk), .code_bus(codes), .col_out(out_a)
  );
  pwm_gray_bank #(.RED_ON_EVEN(1'b0)) u_dut_swap (
    .clk(clk), .rst_n(rst_n), .load_strobe(load), .red_cclk(rclk),
    .green_cclk(gclk), .code_bus(codes), .col_out(out_b)
  );

  function automatic logic [NC-1:0] model(input bit red_even, input int r, input int g);
    logic [NC-1:0] v;
    for (int i = 0; i < NC; i++) begin
      int cnt;
      cnt = (((i % 2) == 0) == red_even) ? r : g;
      v[i] = int'(codes[2*i +: 2]) > cnt;
    end
    return v;
  endfunction

  // Monitor: pops expected items and compares at falling edges
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_tests++;
      if (out_a !== it.exp_a || out_b !== it.exp_b) begin
        n_fail++;
        $display("[TB] FAIL %s: act=%h/%h exp=%h/%h", it.tag, out_a, out_b, it.exp_a, it.exp_b);
      end
    end
  end

  task automatic push_exp(input logic [NC-1:0] ea, input logic [NC-1:0] eb, input string tag);
    item_t it;
    it.exp_a = ea;
    it.exp_b = eb;
    it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic expect_now(input string tag);
    @(posedge clk);
    #1;
    push_exp(model(1'b1, rc, gc), model(1'b0, rc, gc), tag);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_red();
    @(negedge clk) rclk = 1'b1;
    repeat (3) @(negedge clk);
    rclk = 1'b0;
    repeat (3) @(negedge clk);
    if (!load && rc < 3) rc++;
  endtask

  task automatic pulse_green();
    @(negedge clk) gclk = 1'b1;
    repeat (3) @(negedge clk);
    gclk = 1'b0;
    repeat (3) @(negedge clk);
    if (!load && gc < 3) gc++;
  endtask

  task automatic do_load();
    @(negedge clk) load = 1'b1;
    repeat (4) @(negedge clk);
    rc = 0;
    gc = 0;
    load = 1'b0;
    settle();
  endtask

  initial begin
    // pattern A: code of column i is i mod 4
    for (int i = 0; i < NC; i++) codes[2*i +: 2] = 2'(i % 4);
    repeat (3) @(negedge clk);
    push_exp('0, '0, "R1 outputs clear in reset");
    @(negedge clk) rst_n = 1'b1;
    settle();
    expect_now("R1 counters zero after reset");

    // strobe held high, count edges ignored
    @(negedge clk) load = 1'b1;
    settle();
    expect_now("R2 strobe high");
    pulse_red();
    pulse_green();
    expect_now("R2 count edges ignored during strobe");
    @(negedge clk) load = 1'b0;
    settle();

    // latency of one red edge
    @(negedge clk) rclk = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    push_exp(model(1'b1, rc, gc), model(1'b0, rc, gc), "R9 unchanged after third edge");
    @(posedge clk);
    #1;
    rc = 1;
    push_exp(model(1'b1, rc, gc), model(1'b0, rc, gc), "R9 updated on fourth edge");
    @(negedge clk) rclk = 1'b0;
    settle();
    expect_now("R3 red count 1");

    pulse_red();
    expect_now("R3 R5 red count 2");
    pulse_red();
    expect_now("R5 red count 3 all red low");
    pulse_red();
    pulse_red();
    expect_now("R6 red saturates");

    pulse_green();
    expect_now("R4 green count 1");
    pulse_green();
    expect_now("R4 R5 green count 2");
    pulse_green();
    pulse_green();
    expect_now("R6 green saturates");

    // single-column codes for field placement
    codes = '0;
    codes[2*5 +: 2] = 2'b10;
    codes[2*40 +: 2] = 2'b01;
    do_load();
    expect_now("R8 field placement");
    pulse_red();
    expect_now("R8 R7 MSB code survives one red step");
    pulse_green();
    expect_now("R8 R7 LSB code ends on green step");

    // pattern B: all codes 3, green first
    codes = '1;
    do_load();
    expect_now("R5 full codes after load");
    pulse_green();
    pulse_green();
    expect_now("R7 green only two steps");
    pulse_red();
    expect_now("R7 red one step");
    pulse_green();
    expect_now("R7 green columns off");
    pulse_red();
    pulse_red();
    expect_now("R6 all columns off");

    // restart clears saturated counters
    do_load();
    expect_now("R2 reload restarts conversion");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("[TB] FAIL watchdog: act=timeout exp=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule